// File: doc/BRIEF.md
# Class-Steered Integer Issue Queue

This block holds decoded integer instructions until their operands are available and then hands them to one of two integer ALUs. Each cycle up to four new instructions can be written into any free slots. The slots have no order among themselves. Every slot remembers an operation class, a destination tag and two source tags, and each source tag carries a ready flag. A source flag is set when the instruction is written, or later when a matching result tag appears on one of three wakeup lanes.

Each cycle at most one instruction goes to each ALU. The operation class decides which ALU may take an instruction. Branches and shifts go only to the first ALU. Multiplies and divides go only to the second. All other operations may go to either ALU. Among the candidates for an ALU, the oldest one wins. Age is kept as a compact rank per slot: rank 0 is the oldest, and ranks close up whenever entries leave. A slot is freed on the same edge that its instruction issues.

Each slot is a small state machine with three states:
- `SLOT_FREE` is empty.
- `SLOT_WAIT` holds an instruction with at least one missing operand.
- `SLOT_READY` holds an instruction that may issue.

The transitions are:
- *fill-wait* (FREE to WAIT): a write with an operand still missing.
- *fill-ready* (FREE to READY): a write whose operands are all present, counting wakeups in the same cycle.
- *wake* (WAIT to READY): the last missing operand arrives.
- *issue* (READY to FREE): the instruction is granted.

In every other case a slot keeps its state.

Top module: `steer_int_iq`

## Requirements
- R1: After reset all 16 slots are free: `free_cnt` is 16, `full` is 0, `wr_ready` is 1 and neither ALU output is valid.
- R2: When the number of set `wr_valid` lanes is not more than `free_cnt`, all of those lanes are written on the clock edge and `free_cnt` falls by that number; the written instructions can issue from the following cycle.
- R3: When more lanes are requested than `free_cnt`, `wr_ready` is 0 and no lane is written: `free_cnt` does not fall and the rejected instruction never issues.
- R4: An instruction issues only once both source ready flags are set; a wakeup tag on `wk_tag` with its `wk_valid` bit set in cycle t sets every waiting source flag whose tag matches, and the instruction can issue in cycle t+1 at the earliest.
- R5: A wakeup tag presented in the same cycle as a write counts for the instruction being written.
- R6: Class code 2'b01 (branch or shift) issues only on the ALU1 outputs (`a1_*`).
- R7: Class code 2'b10 (multiply or divide) issues only on the ALU2 outputs (`a2_*`).
- R8: Class codes 2'b00 and 2'b11 may issue on either ALU. ALU1 takes the oldest of them only when no class-2'b01 instruction is ready. Otherwise ALU2 may take them, in competition with class 2'b10.
- R9: Among the candidates for one ALU, the oldest wins. Instructions written in the same cycle are older in ascending lane order.
- R10: An issued slot becomes free on the next edge: `free_cnt` rises by the number issued, and the instruction is not issued again.
- R11: At most one instruction per ALU per cycle, and the two ALUs never receive the same slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 4 | Write request per lane |
| wr_cls | input | 8 | Operation class, 2 bits per lane |
| wr_dst | input | 24 | Destination tag, 6 bits per lane |
| wr_src0 | input | 24 | First source tag per lane |
| wr_src1 | input | 24 | Second source tag per lane |
| wr_rdy0 | input | 4 | First source already available, per lane |
| wr_rdy1 | input | 4 | Second source already available, per lane |
| wr_ready | output | 1 | All requested lanes are accepted this cycle |
| wk_valid | input | 3 | Wakeup lane valid |
| wk_tag | input | 18 | Wakeup result tag, 6 bits per lane |
| a1_valid | output | 1 | ALU1 issue valid |
| a1_cls | output | 2 | ALU1 operation class |
| a1_dst | output | 6 | ALU1 destination tag |
| a1_src0 | output | 6 | ALU1 first source tag |
| a1_src1 | output | 6 | ALU1 second source tag |
| a2_valid | output | 1 | ALU2 issue valid |
| a2_cls | output | 2 | ALU2 operation class |
| a2_dst | output | 6 | ALU2 destination tag |
| a2_src0 | output | 6 | ALU2 first source tag |
| a2_src1 | output | 6 | ALU2 second source tag |
| free_cnt | output | 5 | Number of free slots |
| full | output | 1 | No free slot |

## Verification
The bench builds the block with its defaults: 16 slots, four write lanes, three wakeup lanes and 6-bit tags. With four lanes, the queue fills in four cycles of full-width writes. That makes a request against zero free slots reachable, along with a full drain in which the two ALUs alternate by rank. Six-bit tags leave room for distinct destination tags for every instruction. Each expected issue is therefore identified by its tag alone, and any extra issue shows up as an item the scoreboard did not expect.

// File: rtl/iq_pkg.sv
package iq_pkg;

    localparam logic [1:0] CLS_ANY    = 2'b00;
    localparam logic [1:0] CLS_BRSH   = 2'b01;
    localparam logic [1:0] CLS_MULDIV = 2'b10;

    typedef enum logic [1:0] {
        SLOT_FREE  = 2'd0,
        SLOT_WAIT  = 2'd1,
        SLOT_READY = 2'd2
    } slot_st_e;

endpackage

// File: rtl/iq_slot.sv
module iq_slot
    import iq_pkg::*;
#(
    parameter int PTAG_W = 6,
    parameter int WK_N   = 3,
    parameter int RANK_W = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [1:0]               wr_cls,
    input  logic [PTAG_W-1:0]        wr_dst,
    input  logic [PTAG_W-1:0]        wr_src0,
    input  logic [PTAG_W-1:0]        wr_src1,
    input  logic                     wr_rdy0,
    input  logic                     wr_rdy1,
    input  logic [RANK_W-1:0]        wr_rank,
    input  logic [WK_N-1:0]          wk_valid,
    input  logic [WK_N*PTAG_W-1:0]   wk_tag,
    input  logic                     grant,
    input  logic [1:0]               iss_v,
    input  logic [RANK_W-1:0]        iss_rank0,
    input  logic [RANK_W-1:0]        iss_rank1,
    output slot_st_e                 st,
    output logic [1:0]               cls,
    output logic [PTAG_W-1:0]        dst,
    output logic [PTAG_W-1:0]        src0,
    output logic [PTAG_W-1:0]        src1,
    output logic [RANK_W-1:0]        rank
);

    slot_st_e    st_n;
    logic        rdy0_q, rdy1_q;
    logic        in_r0, in_r1, cur_r0, cur_r1;
    logic [RANK_W-1:0] dec;

    function automatic logic tag_hit(input logic [PTAG_W-1:0] t);
        logic h;
        h = 1'b0;
        for (int k = 0; k < WK_N; k++) begin
            if (wk_valid[k] && (wk_tag[k*PTAG_W +: PTAG_W] == t)) h = 1'b1;
        end
        return h;
    endfunction

    assign in_r0  = wr_rdy0 | tag_hit(wr_src0);
    assign in_r1  = wr_rdy1 | tag_hit(wr_src1);
    assign cur_r0 = rdy0_q | tag_hit(src0);
    assign cur_r1 = rdy1_q | tag_hit(src1);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st <= SLOT_FREE;
        else        st <= st_n;
    end

    // transitions: fill-wait, fill-ready, wake, issue
    always_comb begin
        st_n = st;
        unique case (st)
            SLOT_FREE:  if (wr_en) st_n = (in_r0 && in_r1) ? SLOT_READY : SLOT_WAIT;
            SLOT_WAIT:  if (cur_r0 && cur_r1) st_n = SLOT_READY;
            SLOT_READY: if (grant) st_n = SLOT_FREE;
            default:    st_n = SLOT_FREE;
        endcase
    end

    assign dec = RANK_W'(iss_v[0] && (iss_rank0 < rank))
               + RANK_W'(iss_v[1] && (iss_rank1 < rank));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cls    <= '0;
            dst    <= '0;
            src0   <= '0;
            src1   <= '0;
            rdy0_q <= 1'b0;
            rdy1_q <= 1'b0;
            rank   <= '0;
        end else if (wr_en) begin
            cls    <= wr_cls;
            dst    <= wr_dst;
            src0   <= wr_src0;
            src1   <= wr_src1;
            rdy0_q <= in_r0;
            rdy1_q <= in_r1;
            rank   <= wr_rank;
        end else if (st != SLOT_FREE) begin
            rdy0_q <= cur_r0;
            rdy1_q <= cur_r1;
            rank   <= rank - dec;
        end
    end

    AST_GRANT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        grant |-> st == SLOT_READY); // R10
    AST_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        grant |=> st == SLOT_FREE); // R10
    AST_READY_OPS: assert property (@(posedge clk) disable iff (!rst_n)
        (st == SLOT_READY) |-> (rdy0_q && rdy1_q)); // R4
    AST_WR_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> st == SLOT_FREE); // R2

endmodule

// File: rtl/iq_alloc.sv
module iq_alloc #(
    parameter int DEPTH = 16,
    parameter int LANES = 4,
    parameter int LW    = (LANES > 1) ? $clog2(LANES) : 1,
    parameter int LPW   = $clog2(LANES + 1),
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [DEPTH-1:0]       free_vec,
    input  logic [LANES-1:0]       lane_v,
    output logic                   accept,
    output logic [CNT_W-1:0]       free_cnt,
    output logic [DEPTH-1:0]       slot_we,
    output logic [DEPTH*LW-1:0]    slot_lane,
    output logic [LANES*LPW-1:0]   lane_pos
);

    logic [CNT_W-1:0] free_rank [DEPTH];
    logic [LPW-1:0]   req;

    always_comb begin
        logic [CNT_W-1:0] c;
        c = '0;
        for (int j = 0; j < DEPTH; j++) begin
            free_rank[j] = c;
            c = c + CNT_W'(free_vec[j]);
        end
        free_cnt = c;
    end

    always_comb begin
        logic [LPW-1:0] p;
        p = '0;
        for (int l = 0; l < LANES; l++) begin
            lane_pos[l*LPW +: LPW] = p;
            p = p + LPW'(lane_v[l]);
        end
        req = p;
    end

    assign accept = free_cnt >= CNT_W'(req);

    // lane with k-th position lands in the k-th free slot
    always_comb begin
        slot_we   = '0;
        slot_lane = '0;
        for (int j = 0; j < DEPTH; j++) begin
            for (int l = 0; l < LANES; l++) begin
                if (accept && lane_v[l] && free_vec[j] &&
                    (CNT_W'(lane_pos[l*LPW +: LPW]) == free_rank[j])) begin
                    slot_we[j]             = 1'b1;
                    slot_lane[j*LW +: LW]  = LW'(l);
                end
            end
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        accept |-> ($countones(slot_we) == int'(req))); // R2
    AST_REJECT_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        !accept |-> (slot_we == '0)); // R3

endmodule

// File: rtl/iq_pick.sv
module iq_pick #(
    parameter int DEPTH  = 16,
    parameter int RANK_W = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [DEPTH-1:0]        req,
    input  logic [DEPTH*RANK_W-1:0] rank,
    output logic [DEPTH-1:0]        gnt,
    output logic                    any
);

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            gnt[i] = req[i];
            for (int j = 0; j < DEPTH; j++) begin
                if (j != i && req[j] &&
                    (rank[j*RANK_W +: RANK_W] < rank[i*RANK_W +: RANK_W]))
                    gnt[i] = 1'b0;
            end
        end
    end

    assign any = |req;

    AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt)); // R11
    AST_OLDEST_EXISTS: assert property (@(posedge clk) disable iff (!rst_n)
        any |-> (gnt != '0)); // R9

endmodule

// File: rtl/steer_int_iq.sv
module steer_int_iq
    import iq_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int LANES  = 4,
    parameter int WK_N   = 3,
    parameter int PTAG_W = 6
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [LANES-1:0]          wr_valid,
    input  logic [LANES*2-1:0]        wr_cls,
    input  logic [LANES*PTAG_W-1:0]   wr_dst,
    input  logic [LANES*PTAG_W-1:0]   wr_src0,
    input  logic [LANES*PTAG_W-1:0]   wr_src1,
    input  logic [LANES-1:0]          wr_rdy0,
    input  logic [LANES-1:0]          wr_rdy1,
    output logic                      wr_ready,
    input  logic [WK_N-1:0]           wk_valid,
    input  logic [WK_N*PTAG_W-1:0]    wk_tag,
    output logic                      a1_valid,
    output logic [1:0]                a1_cls,
    output logic [PTAG_W-1:0]         a1_dst,
    output logic [PTAG_W-1:0]         a1_src0,
    output logic [PTAG_W-1:0]         a1_src1,
    output logic                      a2_valid,
    output logic [1:0]                a2_cls,
    output logic [PTAG_W-1:0]         a2_dst,
    output logic [PTAG_W-1:0]         a2_src0,
    output logic [PTAG_W-1:0]         a2_src1,
    output logic [$clog2(DEPTH+1)-1:0] free_cnt,
    output logic                      full
);

    localparam int RANK_W = $clog2(DEPTH);
    localparam int CNT_W  = $clog2(DEPTH + 1);
    localparam int LW     = (LANES > 1) ? $clog2(LANES) : 1;
    localparam int LPW    = $clog2(LANES + 1);

    slot_st_e            st_q   [DEPTH];
    logic [1:0]          cls_q  [DEPTH];
    logic [PTAG_W-1:0]   dst_q  [DEPTH];
    logic [PTAG_W-1:0]   s0_q   [DEPTH];
    logic [PTAG_W-1:0]   s1_q   [DEPTH];
    logic [DEPTH*RANK_W-1:0] rank_flat;

    logic [DEPTH-1:0]    free_vec, slot_we;
    logic [DEPTH*LW-1:0] slot_lane;
    logic [LANES*LPW-1:0] lane_pos;
    logic                accept;

    logic [DEPTH-1:0]    c_br, c_md, c_any, req2;
    logic [DEPTH-1:0]    g1_br, g1_any, g1, g2;
    logic                any_br, any_any, any2;
    logic [RANK_W-1:0]   rank1, rank2;
    logic [1:0]          n_iss;
    logic [CNT_W-1:0]    base;

    iq_alloc #(.DEPTH(DEPTH), .LANES(LANES), .LW(LW), .LPW(LPW), .CNT_W(CNT_W)) u_alloc (
        .clk(clk), .rst_n(rst_n), .free_vec(free_vec), .lane_v(wr_valid),
        .accept(accept), .free_cnt(free_cnt), .slot_we(slot_we),
        .slot_lane(slot_lane), .lane_pos(lane_pos)
    );

    assign wr_ready = accept;
    assign full     = (free_cnt == '0);
    assign n_iss    = {1'b0, a1_valid} + {1'b0, a2_valid};
    assign base     = CNT_W'(DEPTH) - free_cnt - CNT_W'(n_iss);

    for (genvar j = 0; j < DEPTH; j++) begin : g_slot
        logic [LW-1:0]     ln;
        logic [RANK_W-1:0] new_rank;
        assign ln       = slot_lane[j*LW +: LW];
        assign new_rank = RANK_W'(base + CNT_W'(lane_pos[ln*LPW +: LPW]));

        iq_slot #(.PTAG_W(PTAG_W), .WK_N(WK_N), .RANK_W(RANK_W)) u_slot (
            .clk(clk), .rst_n(rst_n), .wr_en(slot_we[j]),
            .wr_cls(wr_cls[ln*2 +: 2]),
            .wr_dst(wr_dst[ln*PTAG_W +: PTAG_W]),
            .wr_src0(wr_src0[ln*PTAG_W +: PTAG_W]),
            .wr_src1(wr_src1[ln*PTAG_W +: PTAG_W]),
            .wr_rdy0(wr_rdy0[ln]), .wr_rdy1(wr_rdy1[ln]),
            .wr_rank(new_rank),
            .wk_valid(wk_valid), .wk_tag(wk_tag),
            .grant(g1[j] | g2[j]),
            .iss_v({a2_valid, a1_valid}), .iss_rank0(rank1), .iss_rank1(rank2),
            .st(st_q[j]), .cls(cls_q[j]), .dst(dst_q[j]),
            .src0(s0_q[j]), .src1(s1_q[j]),
            .rank(rank_flat[j*RANK_W +: RANK_W])
        );

        assign free_vec[j] = (st_q[j] == SLOT_FREE);
        assign c_br[j]  = (st_q[j] == SLOT_READY) && (cls_q[j] == CLS_BRSH);
        assign c_md[j]  = (st_q[j] == SLOT_READY) && (cls_q[j] == CLS_MULDIV);
        assign c_any[j] = (st_q[j] == SLOT_READY) && (cls_q[j] != CLS_BRSH)
                                                  && (cls_q[j] != CLS_MULDIV);
    end

    iq_pick #(.DEPTH(DEPTH), .RANK_W(RANK_W)) u_pick_br (
        .clk(clk), .rst_n(rst_n), .req(c_br), .rank(rank_flat), .gnt(g1_br), .any(any_br));
    iq_pick #(.DEPTH(DEPTH), .RANK_W(RANK_W)) u_pick_any (
        .clk(clk), .rst_n(rst_n), .req(c_any), .rank(rank_flat), .gnt(g1_any), .any(any_any));

    assign g1   = any_br ? g1_br : g1_any;
    assign req2 = c_md | (c_any & ~g1);

    iq_pick #(.DEPTH(DEPTH), .RANK_W(RANK_W)) u_pick_a2 (
        .clk(clk), .rst_n(rst_n), .req(req2), .rank(rank_flat), .gnt(g2), .any(any2));

    always_comb begin
        a1_valid = |g1;
        a2_valid = |g2;
        a1_cls = '0; a1_dst = '0; a1_src0 = '0; a1_src1 = '0; rank1 = '0;
        a2_cls = '0; a2_dst = '0; a2_src0 = '0; a2_src1 = '0; rank2 = '0;
        for (int j = 0; j < DEPTH; j++) begin
            if (g1[j]) begin
                a1_cls  |= cls_q[j];
                a1_dst  |= dst_q[j];
                a1_src0 |= s0_q[j];
                a1_src1 |= s1_q[j];
                rank1   |= rank_flat[j*RANK_W +: RANK_W];
            end
            if (g2[j]) begin
                a2_cls  |= cls_q[j];
                a2_dst  |= dst_q[j];
                a2_src0 |= s0_q[j];
                a2_src1 |= s1_q[j];
                rank2   |= rank_flat[j*RANK_W +: RANK_W];
            end
        end
    end

    AST_A1_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
        a1_valid |-> (a1_cls != CLS_MULDIV)); // R7
    AST_A2_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
        a2_valid |-> (a2_cls != CLS_BRSH)); // R6
    AST_ANY_PREFERS_A1: assert property (@(posedge clk) disable iff (!rst_n)
        (a2_valid && a2_cls != CLS_MULDIV) |-> (a1_valid && any2)); // R8
    AST_DISJOINT: assert property (@(posedge clk) disable iff (!rst_n)
        (g1 & g2) == '0); // R11
    AST_BACKPRESSURE: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_ready |=> (free_cnt >= $past(free_cnt))); // R3
    AST_RESET_FREE: assert property (@(posedge clk)
        $rose(rst_n) |-> (free_cnt == CNT_W'(DEPTH))); // R1

endmodule

// File: tb/tb_steer_int_iq.sv
module tb_steer_int_iq;

    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  wr_valid = '0;
    logic [7:0]  wr_cls = '0;
    logic [23:0] wr_dst = '0, wr_src0 = '0, wr_src1 = '0;
    logic [3:0]  wr_rdy0 = '0, wr_rdy1 = '0;
    logic        wr_ready;
    logic [2:0]  wk_valid = '0;
    logic [17:0] wk_tag = '0;
    logic        a1_valid, a2_valid;
    logic [1:0]  a1_cls, a2_cls;
    logic [5:0]  a1_dst, a1_src0, a1_src1, a2_dst, a2_src0, a2_src1;
    logic [4:0]  free_cnt;
    logic        full;

    typedef struct { int dst; string req; } exp_t;
    exp_t q1[$];
    exp_t q2[$];
    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #(CLK_P/2) clk = ~clk;

    steer_int_iq dut (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_cls(wr_cls),
        .wr_dst(wr_dst), .wr_src0(wr_src0), .wr_src1(wr_src1),
        .wr_rdy0(wr_rdy0), .wr_rdy1(wr_rdy1), .wr_ready(wr_ready),
        .wk_valid(wk_valid), .wk_tag(wk_tag),
        .a1_valid(a1_valid), .a1_cls(a1_cls), .a1_dst(a1_dst),
        .a1_src0(a1_src0), .a1_src1(a1_src1),
        .a2_valid(a2_valid), .a2_cls(a2_cls), .a2_dst(a2_dst),
        .a2_src0(a2_src0), .a2_src1(a2_src1),
        .free_cnt(free_cnt), .full(full)
    );

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
        end
    endtask

    task automatic put(input int lane, input logic [1:0] cls, input int dst,
                       input int s0, input int s1, input bit r0, input bit r1);
        wr_valid[lane]          = 1'b1;
        wr_cls[lane*2 +: 2]     = cls;
        wr_dst[lane*6 +: 6]     = 6'(dst);
        wr_src0[lane*6 +: 6]    = 6'(s0);
        wr_src1[lane*6 +: 6]    = 6'(s1);
        wr_rdy0[lane]           = r0;
        wr_rdy1[lane]           = r1;
    endtask

    task automatic wake(input int lane, input int tag);
        wk_valid[lane]       = 1'b1;
        wk_tag[lane*6 +: 6]  = 6'(tag);
    endtask

    task automatic commit(output bit rdy);
        #1;
        rdy = wr_ready;
        @(posedge clk);
        #1;
        wr_valid = '0; wr_cls = '0; wr_dst = '0; wr_src0 = '0; wr_src1 = '0;
        wr_rdy0 = '0; wr_rdy1 = '0; wk_valid = '0; wk_tag = '0;
    endtask

    task automatic idle(input int n);
        bit r;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            commit(r);
        end
    endtask

    task automatic exp1(input int d, input string rq);
        exp_t e; e.dst = d; e.req = rq; q1.push_back(e);
    endtask

    task automatic exp2(input int d, input string rq);
        exp_t e; e.dst = d; e.req = rq; q2.push_back(e);
    endtask

    task automatic drained(input string rq);
        chk(q1.size() == 0, {rq, " ALU1 items left"}, q1.size(), 0);
        chk(q2.size() == 0, {rq, " ALU2 items left"}, q2.size(), 0);
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // monitor: compares issues against the scoreboard queues
    initial begin
        forever begin
            @(posedge clk);
            #(CLK_P/4);
            if (rst_n) begin
                if (a1_valid) begin
                    if (q1.size() == 0) begin
                        chk(1'b0, "R6/R11 unexpected ALU1 issue", a1_dst, -1);
                    end else begin
                        exp_t e;
                        e = q1.pop_front();
                        chk(a1_dst == 6'(e.dst), {e.req, " ALU1 dst"}, a1_dst, e.dst);
                    end
                end
                if (a2_valid) begin
                    if (q2.size() == 0) begin
                        chk(1'b0, "R7/R11 unexpected ALU2 issue", a2_dst, -1);
                    end else begin
                        exp_t e;
                        e = q2.pop_front();
                        chk(a2_dst == 6'(e.dst), {e.req, " ALU2 dst"}, a2_dst, e.dst);
                    end
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
        end
    end

    initial begin
        bit r;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        #2;
        // R1 reset state
        chk(free_cnt == 5'd16, "R1 free_cnt", free_cnt, 16);
        chk(full == 1'b0, "R1 full", full, 0);
        chk(wr_ready == 1'b1, "R1 wr_ready", wr_ready, 1);
        chk(!a1_valid && !a2_valid, "R1 no issue", {a1_valid, a2_valid}, 0);

        // R6 R7 R9: four ready entries in one cycle
        exp1(1, "R6"); exp1(3, "R9");
        exp2(2, "R7"); exp2(4, "R9");
        @(negedge clk);
        put(0, 2'b01, 1, 0, 0, 1, 1);
        put(1, 2'b10, 2, 0, 0, 1, 1);
        put(2, 2'b01, 3, 0, 0, 1, 1);
        put(3, 2'b10, 4, 0, 0, 1, 1);
        commit(r);
        chk(r == 1'b1, "R2 accept four", r, 1);
        chk(free_cnt == 5'd12, "R2 free after write", free_cnt, 12);
        idle(3);
        chk(free_cnt == 5'd16, "R10 free after drain", free_cnt, 16);
        drained("R9");

        // R8 steering of either-class entries
        exp1(11, "R8"); exp2(10, "R8");
        @(negedge clk);
        put(0, 2'b00, 10, 0, 0, 1, 1);
        put(1, 2'b01, 11, 0, 0, 1, 1);
        commit(r);
        idle(2);
        exp1(12, "R9"); exp2(13, "R8");
        @(negedge clk);
        put(0, 2'b00, 12, 0, 0, 1, 1);
        put(1, 2'b11, 13, 0, 0, 1, 1);
        commit(r);
        idle(2);
        exp1(14, "R8"); exp2(15, "R7");
        @(negedge clk);
        put(0, 2'b10, 15, 0, 0, 1, 1);
        put(1, 2'b00, 14, 0, 0, 1, 1);
        commit(r);
        idle(2);
        drained("R8");

        // R4 waits for both sources, woken one at a time
        @(negedge clk);
        put(0, 2'b00, 20, 5, 6, 0, 0);
        commit(r);
        idle(3);
        chk(free_cnt == 5'd15, "R4 still held", free_cnt, 15);
        @(negedge clk);
        wake(0, 5);
        commit(r);
        idle(2);
        chk(free_cnt == 5'd15, "R4 one source only", free_cnt, 15);
        exp1(20, "R4");
        @(negedge clk);
        wake(1, 6);
        commit(r);
        idle(2);
        chk(free_cnt == 5'd16, "R4 issued after wake", free_cnt, 16);

        // R5 wakeup in the write cycle
        exp1(21, "R5");
        @(negedge clk);
        put(2, 2'b00, 21, 7, 8, 0, 1);
        wake(2, 7);
        commit(r);
        idle(2);
        chk(free_cnt == 5'd16, "R5 issued", free_cnt, 16);
        drained("R5");

        // R3 fill to full, reject one more, then drain by age
        for (int c = 0; c < 4; c++) begin
            @(negedge clk);
            for (int l = 0; l < 4; l++) put(l, 2'b00, 30 + 4*c + l, 9, 0, 0, 1);
            commit(r);
            chk(r == 1'b1, "R2 fill accepted", r, 1);
            chk(free_cnt == 5'(12 - 4*c), "R2 fill count", free_cnt, 12 - 4*c);
        end
        chk(full == 1'b1, "R3 full flag", full, 1);
        @(negedge clk);
        put(1, 2'b00, 63, 0, 0, 1, 1);
        commit(r);
        chk(r == 1'b0, "R3 wr_ready low", r, 0);
        chk(free_cnt == 5'd0, "R3 nothing written", free_cnt, 0);
        for (int i = 0; i < 8; i++) begin
            exp1(30 + 2*i, "R9");
            exp2(31 + 2*i, "R9");
        end
        @(negedge clk);
        wake(0, 9);
        commit(r);
        @(posedge clk);
        #1;
        chk(free_cnt == 5'd2, "R10 freed on next edge", free_cnt, 2);
        idle(10);
        chk(free_cnt == 5'd16, "R10 all freed", free_cnt, 16);
        drained("R3");

        done = 1;
        summary();
    end

endmodule